// File: doc/BRIEF.md
# Page Write Load Controller

This block is a clock-synchronous model of the write front end of a byte-wide parallel EEPROM. The host drives an active-low chip select, write strobe and output enable, an address and a data byte. The block samples all of them on the system clock. Each accepted write strobe loads one byte into a page buffer. The first byte of a page locks the page number. Later bytes must carry the same page number or they are dropped. A byte-load window timer restarts on every accepted strobe. The page stays open for as long as strobes keep arriving inside that window, with no limit on its total length.

When the window runs out with no strobe open, the block starts an internal programming cycle of fixed length and raises `busy`. When that cycle ends, every buffered byte is committed to a behavioural memory array in a single clock. A read strobe returns array contents on a registered output. The address width is a parameter. The default keeps the array small, and a width of 15 gives a 32 KiB array.

Top module: `page_write_loader`

## Requirements
- R1: After reset `busy` is 0 and `rd_data` is 0.
- R2: A write strobe begins only in a sampled cycle where `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe seen with `oe_n` low, or with `ce_n` high, loads nothing and starts no programming.
- R3: The byte address is taken from the first sampled cycle in which `ce_n` and `we_n` are both low. The data byte is taken from the first sampled cycle in which either of them is high again. Address changes in between have no effect.
- R4: One programming cycle commits between 1 and 64 bytes. `addr[5:0]` selects the byte in the page and `addr[ADDR_W-1:6]` is the page number. When the same offset is loaded twice, the later byte wins.
- R5: While a page is open, a strobe whose page number differs from the locked page is ignored. It loads no byte and does not restart the window.
- R6: Programming starts when the window expires with no strobe open. `busy` first reads 1 exactly WINDOW_CYC+2 clock edges after the edge that first samples the last accepted strobe start.
- R7: A page stays open across any number of strobes, each of which starts within the window of the one before it, and it is committed by a single programming cycle.
- R8: `busy` stays high for exactly PROG_CYC cycles. Reads while it is high return the old array contents. The new bytes are readable once `busy` is low.
- R9: Write strobes that begin while `busy` is high are ignored. They write nothing and start no later programming.
- R10: A read is a sampled cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1. `rd_data` holds `mem[addr]` from the second clock edge after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; upper bits page, low 6 bits offset |
| din | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| busy | output | 1 | High during the internal programming cycle |

## Verification
The bench measures the exact edge on which `busy` rises after the last accepted strobe. A design that restarted the window on a strobe from a foreign page, or that counted the window from the wrong edge, shows up as a shifted rise. It moves the address and the data while a strobe is open. A design that latched the address late would write the wrong offset, and one that latched the data early would store the first byte instead of the final one. It reads a page while that page is being programmed and strobes during `busy`. A design that committed early would return new data during `busy`, and one that accepted strobes in that state would start a stray second cycle. Random pages with repeated offsets check that the last byte loaded at an offset is the one committed.

// File: rtl/pwl_pkg.sv
// Package: shared types of the page write loader.
// Assumes: nothing beyond IEEE 1800-2017.
package pwl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pwl_state_e;
endpackage

// File: rtl/pwl_strobe_detect.sv
// Module: registers the host control, address and data pins once and
// derives write start, write end and read events from them.
// Assumes: host pins are synchronous to clk (no metastability handling).
module pwl_strobe_detect #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              oe_q,
    output logic              start_evt,
    output logic              end_evt,
    output logic              rd_evt,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q
);
    logic ce_q;
    logic we_q;
    logic act_d;
    logic act_now;

    // Both strobes low in the current sample.
    assign act_now = ~ce_q & ~we_q;

    // Sample host pins and keep last strobe state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b1;
            we_q   <= 1'b1;
            oe_q   <= 1'b1;
            act_d  <= 1'b0;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            ce_q   <= ce_n;
            we_q   <= we_n;
            oe_q   <= oe_n;
            act_d  <= act_now;
            addr_q <= addr;
            din_q  <= din;
        end
    end

    // Later falling edge with output disabled opens a write.
    assign start_evt = act_now & ~act_d & oe_q;
    // Earlier rising edge closes it.
    assign end_evt   = ~act_now & act_d;
    // Read access: selected, output enabled, not writing.
    assign rd_evt    = ~ce_q & ~oe_q & we_q;
endmodule

// File: rtl/pwl_page_buffer.sv
// Module: page-sized byte buffer with a per-byte valid flag.
// Assumes: clr and wr_en are never high in the same cycle; clr wins if so.
module pwl_page_buffer #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8,
    localparam int PAGE_BYTES = 1 << OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [OFF_W-1:0]             wr_off,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         clr,
    output logic [PAGE_BYTES*DATA_W-1:0] data_o,
    output logic [PAGE_BYTES-1:0]        valid_o
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        logic [DATA_W-1:0] b_q;
        logic              v_q;

        // Hold one byte slot and its valid flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                b_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_off == OFF_W'(g))) begin
                b_q <= wr_data;
                v_q <= 1'b1;
            end
        end

        assign data_o[g*DATA_W +: DATA_W] = b_q;
        assign valid_o[g]                 = v_q;
    end
endmodule

// File: rtl/pwl_seq.sv
// Module: load/program sequencer. Locks the page on the first byte, runs
// the byte-load window timer and the programming counter.
// Assumes: WINDOW_CYC >= 1 and PROG_CYC >= 1.
module pwl_seq
    import pwl_pkg::*;
#(
    parameter int WINDOW_CYC = 40,
    parameter int PROG_CYC   = 60,
    parameter int PAGE_W     = 5,
    parameter int OFF_W      = 6,
    localparam int TMR_W = $clog2(WINDOW_CYC + 1),
    localparam int PRG_W = $clog2(PROG_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              end_evt,
    input  logic [PAGE_W-1:0] addr_page,
    input  logic [OFF_W-1:0]  addr_off,
    output logic              busy,
    output logic              st_load,
    output logic [TMR_W-1:0]  timer,
    output logic [PAGE_W-1:0] page_lock,
    output logic              buf_wr,
    output logic [OFF_W-1:0]  buf_off,
    output logic              commit
);
    pwl_state_e       state;
    logic             acc;
    logic             start_ok;
    logic [PRG_W-1:0] pcnt;

    // Accept a start when idle, or when loading the locked page.
    assign start_ok = start_evt &&
                      ((state == ST_IDLE) ||
                       ((state == ST_LOAD) && (addr_page == page_lock)));

    // State, window timer, programming counter and open-strobe flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            acc       <= 1'b0;
            buf_off   <= '0;
            timer     <= '0;
            pcnt      <= '0;
            page_lock <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        page_lock <= addr_page;
                        buf_off   <= addr_off;
                        acc       <= 1'b1;
                        timer     <= TMR_W'(WINDOW_CYC);
                        state     <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (start_ok) begin
                        buf_off <= addr_off;
                        acc     <= 1'b1;
                        timer   <= TMR_W'(WINDOW_CYC);
                    end else begin
                        if (end_evt) begin
                            acc <= 1'b0;
                        end
                        if (timer != '0) begin
                            timer <= timer - 1'b1;
                        end else if (!acc) begin
                            pcnt  <= PRG_W'(PROG_CYC - 1);
                            state <= ST_PROG;
                        end
                    end
                end
                ST_PROG: begin
                    if (pcnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        pcnt <= pcnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state == ST_PROG);
    assign st_load = (state == ST_LOAD);
    assign buf_wr  = end_evt && acc;
    assign commit  = (state == ST_PROG) && (pcnt == '0);
endmodule

// File: rtl/pwl_mem_array.sv
// Module: behavioural byte array with a one-clock page commit and a
// registered read port.
// Assumes: contents are undefined until written; a read in the commit
// cycle returns the old value.
module pwl_mem_array #(
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8,
    localparam int PAGE_W     = ADDR_W - OFF_W,
    localparam int PAGE_BYTES = 1 << OFF_W,
    localparam int DEPTH      = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [PAGE_W-1:0]            page,
    input  logic [PAGE_BYTES*DATA_W-1:0] buf_data,
    input  logic [PAGE_BYTES-1:0]        buf_valid,
    input  logic                         rd_evt,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Commit every valid buffered byte of the page.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (buf_valid[i]) begin
                    mem[{page, OFF_W'(i)}] <= buf_data[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_evt) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/page_write_loader.sv
// Module: top of the page write loader. Connects strobe detection, the
// sequencer, the page buffer and the memory array.
// Assumes: ADDR_W > OFF_W; host pins synchronous to clk.
module page_write_loader #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = 6,
    parameter int WINDOW_CYC = 40,
    parameter int PROG_CYC   = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int PAGE_W     = ADDR_W - OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int TMR_W      = $clog2(WINDOW_CYC + 1);

    logic                         oe_q;
    logic                         start_evt;
    logic                         end_evt;
    logic                         rd_evt;
    logic [ADDR_W-1:0]            addr_q;
    logic [DATA_W-1:0]            din_q;
    logic                         st_load;
    logic [TMR_W-1:0]             timer;
    logic [PAGE_W-1:0]            page_lock;
    logic                         buf_wr;
    logic [OFF_W-1:0]             buf_off;
    logic                         commit;
    logic [PAGE_BYTES*DATA_W-1:0] buf_data;
    logic [PAGE_BYTES-1:0]        buf_valid;

    pwl_strobe_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .din       (din),
        .oe_q      (oe_q),
        .start_evt (start_evt),
        .end_evt   (end_evt),
        .rd_evt    (rd_evt),
        .addr_q    (addr_q),
        .din_q     (din_q)
    );

    pwl_seq #(
        .WINDOW_CYC (WINDOW_CYC),
        .PROG_CYC   (PROG_CYC),
        .PAGE_W     (PAGE_W),
        .OFF_W      (OFF_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .end_evt   (end_evt),
        .addr_page (addr_q[ADDR_W-1:OFF_W]),
        .addr_off  (addr_q[OFF_W-1:0]),
        .busy      (busy),
        .st_load   (st_load),
        .timer     (timer),
        .page_lock (page_lock),
        .buf_wr    (buf_wr),
        .buf_off   (buf_off),
        .commit    (commit)
    );

    pwl_page_buffer #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_off  (buf_off),
        .wr_data (din_q),
        .clr     (commit),
        .data_o  (buf_data),
        .valid_o (buf_valid)
    );

    pwl_mem_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .page      (page_lock),
        .buf_data  (buf_data),
        .buf_valid (buf_valid),
        .rd_evt    (rd_evt),
        .rd_addr   (addr_q),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/pwl_checker.sv
// Module: temporal checks on the page write loader, bound to its top.
// Assumes: reset is held for at least one clock at start.
module pwl_checker #(
    parameter int WINDOW_CYC = 40,
    parameter int PROG_CYC   = 60,
    parameter int PAGE_W     = 5,
    localparam int TMR_W = $clog2(WINDOW_CYC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              st_load,
    input logic              oe_q,
    input logic [TMR_W-1:0]  timer,
    input logic [PAGE_W-1:0] page_lock
);
    int bcnt;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= 0;
        end else begin
            bcnt <= busy ? bcnt + 1 : 0;
        end
    end

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == PROG_CYC));

    // R6
    win_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(timer) == '0));

    // R6
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer <= TMR_W'(WINDOW_CYC));

    // R2
    start_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_load) |-> $past(oe_q));

    // R5
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_load |=> $stable(page_lock));

    // R9
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(page_lock));
endmodule

bind page_write_loader pwl_checker #(
    .WINDOW_CYC (WINDOW_CYC),
    .PROG_CYC   (PROG_CYC),
    .PAGE_W     (ADDR_W - OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .st_load   (st_load),
    .oe_q      (oe_q),
    .timer     (timer),
    .page_lock (page_lock)
);

// File: tb/page_write_loader_test.sv
module page_write_loader_test;
    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int WIN = 40;
    localparam int PRG = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] rd_data;
    logic          busy;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int last_start = 0;

    bit [7:0] ref_mem [0:2047];
    bit [7:0] pd [0:63];
    bit       pv [0:63];
    int       ppage = 0;

    page_write_loader #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(6),
                        .WINDOW_CYC(WIN), .PROG_CYC(PRG)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .rd_data(rd_data), .busy(busy)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_rise_delay();
        return WIN + 3;
    endfunction

    function automatic bit [AW-1:0] mk_addr(input int page, input int off);
        return AW'((page << 6) | (off & 63));
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input bit [AW-1:0] a, input bit [7:0] d,
                          input bit oe_lvl, input bit ce_lvl);
        addr = a; din = d; oe_n = oe_lvl; ce_n = ce_lvl; we_n = 1'b0;
        tick(2);
        we_n = 1'b1;
        tick(1);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    task automatic load(input bit [AW-1:0] a, input bit [7:0] d);
        last_start = cyc;
        strobe(a, d, 1'b1, 1'b0);
        ppage = int'(a >> 6);
        pd[a[5:0]] = d;
        pv[a[5:0]] = 1'b1;
    endtask

    // Address switched and data changed while the strobe is open.
    task automatic load_var(input bit [AW-1:0] a, input bit [7:0] d0,
                            input bit [AW-1:0] a2, input bit [7:0] d1);
        last_start = cyc;
        addr = a; din = d0; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        tick(1);
        addr = a2; din = d1;
        tick(1);
        we_n = 1'b1;
        tick(1);
        ce_n = 1'b1;
        tick(1);
        ppage = int'(a >> 6);
        pd[a[5:0]] = d1;
        pv[a[5:0]] = 1'b1;
    endtask

    task automatic read_byte(input bit [AW-1:0] a, output bit [7:0] v);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        tick(3);
        v = rd_data;
        ce_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    task automatic check_read(input string tag, input bit [AW-1:0] a);
        bit [7:0] v;
        read_byte(a, v);
        check(tag, int'(v), int'(ref_mem[a]));
    endtask

    task automatic wait_busy_high();
        for (int k = 0; k < 4 * WIN && !busy; k++) tick(1);
    endtask

    task automatic wait_busy_low();
        for (int k = 0; k < 4 * PRG && busy; k++) tick(1);
    endtask

    // Wait for the programming cycle, checking its start and length.
    task automatic commit_wait(input string tag);
        int n;
        wait_busy_high();
        check({tag, " R6 busy rise delay"}, cyc - last_start, exp_rise_delay());
        n = 0;
        while (busy && n < 4 * PRG) begin
            n++;
            tick(1);
        end
        check({tag, " R8 busy length"}, n, PRG);
        for (int i = 0; i < 64; i++) begin
            if (pv[i]) ref_mem[mk_addr(ppage, i)] = pd[i];
            pv[i] = 1'b0;
        end
    endtask

    task automatic quiet_check(input string tag, input int n);
        int seen;
        seen = 0;
        for (int k = 0; k < n; k++) begin
            if (busy) seen = 1;
            tick(1);
        end
        check(tag, seen, 0);
    endtask

    initial begin
        bit [7:0] v;
        for (int i = 0; i < 64; i++) pv[i] = 1'b0;
        void'($urandom(32'd20240611));
        tick(5);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        check("R1 busy after reset", int'(busy), 0);
        check("R1 rd_data after reset", int'(rd_data), 0);

        // R4, R10: single-byte page
        load(11'h085, 8'h3C);
        commit_wait("single");
        check_read("R10 single byte readback", 11'h085);

        // R3: address from start, data from end
        load(11'h0C7, 8'h77);
        load_var(11'h0C0, 8'h11, 11'h0C7, 8'h5A);
        commit_wait("latch");
        check_read("R3 data at strobe end", 11'h0C0);
        check_read("R3 late address ignored", 11'h0C7);

        // R4: full 64-byte page, descending offsets
        for (int i = 63; i >= 0; i--) load(mk_addr(4, i), 8'(i * 3 + 1));
        commit_wait("fullpage");
        for (int i = 0; i < 64; i++) check_read("R4 full page byte", mk_addr(4, i));

        // R5: foreign page strobe ignored, window not restarted
        load(11'h105, 8'hA0);
        strobe(11'h0C0, 8'hEE, 1'b1, 1'b0);
        commit_wait("R5");
        check_read("R5 locked page byte", 11'h105);
        check_read("R5 foreign byte not written", 11'h0C0);

        // R7: long chain of strobes inside the window
        for (int i = 0; i < 6; i++) begin
            load(mk_addr(8, i * 7), 8'(8'hC0 + i));
            if (i != 5) tick(WIN / 2);
        end
        commit_wait("R7 chain");
        for (int i = 0; i < 6; i++) check_read("R7 chain byte", mk_addr(8, i * 7));

        // R8: old data readable during busy
        load(11'h105, 8'h55);
        wait_busy_high();
        read_byte(11'h105, v);
        check("R8 old data during busy", int'(v), int'(ref_mem[11'h105]));
        wait_busy_low();
        ref_mem[11'h105] = 8'h55;
        pv[5] = 1'b0;
        check_read("R8 new data after busy", 11'h105);

        // R9: strobe during busy ignored
        load(11'h300, 8'h12);
        wait_busy_high();
        strobe(11'h085, 8'hFF, 1'b1, 1'b0);
        wait_busy_low();
        ref_mem[11'h300] = 8'h12;
        pv[0] = 1'b0;
        quiet_check("R9 no later programming", WIN + 8);
        check_read("R9 busy-time strobe not written", 11'h085);
        check_read("R9 page byte written", 11'h300);

        // R2: blocked strobes
        strobe(11'h085, 8'h99, 1'b0, 1'b0);
        quiet_check("R2 oe low starts nothing", WIN + 8);
        strobe(11'h085, 8'h98, 1'b1, 1'b1);
        quiet_check("R2 ce high starts nothing", WIN + 8);
        check_read("R2 blocked strobes write nothing", 11'h085);

        // R4, R6, R8: random pages with repeated offsets
        for (int p = 0; p < 8; p++) begin
            int pg;
            int cnt;
            pg = 16 + int'($urandom_range(0, 15));
            cnt = int'($urandom_range(1, 64));
            for (int j = 0; j < cnt; j++) begin
                load(mk_addr(pg, int'($urandom_range(0, 63))), 8'($urandom));
                tick(int'($urandom_range(0, WIN - 6)));
            end
            commit_wait("random");
            for (int i = 0; i < 64; i += 3) begin
                if (ref_mem[mk_addr(pg, i)] != 8'h00)
                    check_read("R4 random page byte", mk_addr(pg, i));
            end
        end

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule